// File: doc/BRIEF.md
# Shaper Rate Parameter Encoder

This block turns a requested shaping rate, in bytes per second, into the three fields a time-wheel shaper uses: an 8-bit mantissa, a 4-bit shift exponent and a 4-bit divider exponent. In its second mode it turns a requested burst size, in bytes, into a burst mantissa and a burst exponent. The encoded rate is `floor(1e9 * ((256 + m) << e) / ((T << d) * 256))`. T is the tick period of the time wheel: 240 when the top-level select is high and 860 otherwise. The encoded burst is `((256 + m) << (e + 1)) / 256`.

The encoder is sequential. A caller presents the request with a one-cycle start strobe. The block first checks that the request lies in range. It then searches downward one step per clock cycle for the largest encoding that does not exceed the request. Finally it recomputes the value the chosen fields really give. A single-cycle done strobe returns the fields and that achieved value, with an error flag set if the request was refused. Every comparison in the search is made by cross-multiplication. The only division, the final recomputation, runs on a bit-serial divider.

Top module: `shaper_param_encoder`

## Requirements
- R1: After reset, busy, done and error are low, and every field output and the achieved value are zero.
- R2: A request below the smallest encodable value is refused. For a rate that is floor(1e9/(T*4096)); for a burst it is 2. Done rises in the second cycle after start is taken, with error high and all fields and the achieved value zero.
- R3: A request above the largest encodable value is refused in the third cycle after start is taken, with error high and all outputs zero. For a rate that is floor(1e9*511*128/T); for a burst it is 130816.
- R4: A rate request not above floor(1e9/T) gets exponent 0. The divider exponent is the first d, counting up from 0, with request >= floor(1e9/(T<<d)). The mantissa is the first m, counting down from 255, whose encoded rate does not exceed the request.
- R5: A rate request above floor(1e9/T) gets divider exponent 0. The exponent is the first e, counting down from 15, with request >= floor(1e9*2^e/T). The mantissa is then chosen by the same downward rule.
- R6: The tick period T is 240 when the top-level select (top_lvl_i = 1) is captured with start, and 860 otherwise.
- R7: With mode_i = 1 (burst), the exponent is the first e, counting down from 15, with request >= 2^(e+1). The mantissa is then the first m, counting down from 255, with request >= ((256+m) << (e+1)) / 256. The divider exponent output is 0. With mode_i = 0 the request is a rate.
- R8: Burst requests outside the range 2 to 130816 are refused with error high and a zero result.
- R9: On success the achieved output equals the encoding formula evaluated on the returned fields, and error is low.
- R10: Done is high for exactly one cycle per request. Busy is high from the cycle after start is taken until done rises, and low while done is high.
- R11: A start strobe that arrives while busy is ignored: the result belongs to the request taken first.
- R12: Fields, achieved value and error hold their values between done strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| mode_i | input | 1 | 0 = rate request, 1 = burst request |
| top_lvl_i | input | 1 | 1 selects the top-level tick period |
| req_i | input | REQ_W | Requested rate (bytes/s) or burst (bytes) |
| busy_o | output | 1 | Search or recomputation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Request was out of range |
| mant_o | output | MANT_W | Encoded mantissa |
| exp_o | output | EXP_W | Encoded shift exponent |
| dexp_o | output | DEXP_W | Encoded divider exponent |
| achieved_o | output | REQ_W | Value the returned fields produce |

## Verification
Refusals arrive at fixed times. A too-small request raises done in the second cycle after start is taken, and a too-large one in the third. The bench counts falling edges from start to done and checks those exact counts. Accepted requests finish after a data-dependent search plus the serial division, so the bench waits for the done strobe and compares every output in that cycle against a reference that performs the same searches with true division. In the cycle that follows it checks that done has fallen and that the outputs stay unchanged across idle cycles.

// File: rtl/shaper_enc_pkg.sv
package shaper_enc_pkg;

   typedef enum logic {
      ENC_RATE  = 1'b0,
      ENC_BURST = 1'b1
   } enc_mode_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CHK_LO,
      ST_CHK_HI,
      ST_CHK_BR,
      ST_DIV_UP,
      ST_EXP_DN,
      ST_MANT_DN,
      ST_DIV_GO,
      ST_DIV_WAIT
   } enc_state_e;

endpackage

// File: rtl/shaper_enc_terms.sv
// Forms numerator and denominator of the encoded value for a given
// (exponent, mantissa, divider exponent) so that value = floor(num/den).
module shaper_enc_terms
   import shaper_enc_pkg::*;
#(
   parameter int CLK_HZ   = 1_000_000_000,
   parameter int TICK_TOP = 240,
   parameter int TICK_LOW = 860,
   parameter int MANT_W   = 8,
   parameter int EXP_W    = 4,
   parameter int DEXP_W   = 4,
   parameter int NUM_W    = 54,
   parameter int DEN_W    = 30
) (
   input  enc_mode_e          mode_i,
   input  logic               top_i,
   input  logic [EXP_W-1:0]   e_i,
   input  logic [MANT_W-1:0]  m_i,
   input  logic [DEXP_W-1:0]  d_i,
   output logic [NUM_W-1:0]   num_o,
   output logic [DEN_W-1:0]   den_o
);

   localparam int MANT_ONE = 1 << MANT_W;

   logic [NUM_W-1:0]   base;
   logic [DEN_W-1:0]   tick;
   logic [EXP_W:0]     burst_sh;

   always_comb begin
      base     = NUM_W'(MANT_ONE) + NUM_W'(m_i);
      tick     = top_i ? DEN_W'(TICK_TOP) : DEN_W'(TICK_LOW);
      burst_sh = (EXP_W+1)'(e_i) + (EXP_W+1)'(1);
      if (mode_i == ENC_RATE) begin
         num_o = NUM_W'(CLK_HZ) * (base << e_i);
         den_o = (tick << d_i) << MANT_W;
      end else begin
         num_o = base << burst_sh;
         den_o = DEN_W'(MANT_ONE);
      end
   end

endmodule

// File: rtl/shaper_div_seq.sv
// Bit-serial restoring divider: one quotient bit per cycle.
module shaper_div_seq #(
   parameter int NUM_W = 54,
   parameter int DEN_W = 30,
   parameter int QUO_W = 40
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [NUM_W-1:0]   num_i,
   input  logic [DEN_W-1:0]   den_i,
   output logic               done_o,
   output logic [QUO_W-1:0]   quo_o
);

   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [NUM_W-1:0] q_q;
   logic [DEN_W-1:0] r_q;
   logic [DEN_W-1:0] den_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             done_q;

   logic [DEN_W:0]   shifted;
   logic [DEN_W:0]   diff;
   logic             fits;

   always_comb begin
      shifted = {r_q, q_q[NUM_W-1]};
      fits    = shifted >= {1'b0, den_q};
      diff    = shifted - {1'b0, den_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_q    <= '0;
         r_q    <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            q_q   <= num_i;
            r_q   <= '0;
            den_q <= den_i;
            cnt_q <= CNT_W'(NUM_W);
            run_q <= 1'b1;
         end else if (run_q) begin
            r_q   <= fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
            q_q   <= {q_q[NUM_W-2:0], fits};
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done_o = done_q;
   assign quo_o  = q_q[QUO_W-1:0];

   // R9: the recomputation finishes with a single strobe
   a_r9_div_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R9: a running division always has bits left to produce
   a_r9_div_count_live: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> cnt_q != '0);

endmodule

// File: rtl/shaper_enc_ctrl.sv
// Range check, branch choice and one-step-per-cycle downward search.
module shaper_enc_ctrl
   import shaper_enc_pkg::*;
#(
   parameter int REQ_W    = 40,
   parameter int MANT_W   = 8,
   parameter int EXP_W    = 4,
   parameter int DEXP_W   = 4,
   parameter int DEXP_MAX = 12,
   parameter int NUM_W    = 54,
   parameter int DEN_W    = 30
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               mode_i,
   input  logic               top_i,
   input  logic [REQ_W-1:0]   req_i,
   output enc_mode_e          t_mode_o,
   output logic               t_top_o,
   output logic [EXP_W-1:0]   t_e_o,
   output logic [MANT_W-1:0]  t_m_o,
   output logic [DEXP_W-1:0]  t_d_o,
   input  logic [NUM_W-1:0]   num_i,
   input  logic [DEN_W-1:0]   den_i,
   output logic               div_start_o,
   input  logic               div_done_i,
   input  logic [REQ_W-1:0]   div_quo_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               err_o,
   output logic [MANT_W-1:0]  mant_o,
   output logic [EXP_W-1:0]   exp_o,
   output logic [DEXP_W-1:0]  dexp_o,
   output logic [REQ_W-1:0]   achieved_o
);

   localparam int CMP_W = ((REQ_W + DEN_W + 1) > NUM_W ? (REQ_W + DEN_W + 1) : NUM_W) + 1;

   enc_state_e        state_q;
   enc_mode_e         mode_q;
   logic              top_q;
   logic [REQ_W-1:0]  req_q;
   logic [EXP_W-1:0]  e_q;
   logic [MANT_W-1:0] m_q;
   logic [DEXP_W-1:0] d_q;
   logic              done_q, err_q;
   logic [MANT_W-1:0] mant_q;
   logic [EXP_W-1:0]  exp_q;
   logic [DEXP_W-1:0] dexp_q;
   logic [REQ_W-1:0]  ach_q;

   logic [CMP_W-1:0]  lhs_at, lhs_next, rhs;
   logic              below, above, reject;

   // below: req < floor(num/den); above: req > floor(num/den)
   always_comb begin
      rhs      = CMP_W'(num_i);
      lhs_at   = CMP_W'(req_q) * CMP_W'(den_i);
      lhs_next = lhs_at + CMP_W'(den_i);
      below    = lhs_next <= rhs;
      above    = lhs_at > rhs;
      reject   = ((state_q == ST_CHK_LO) && below) ||
                 ((state_q == ST_CHK_HI) && above);
   end

   always_comb begin
      t_e_o = e_q;
      t_m_o = m_q;
      t_d_o = d_q;
      case (state_q)
         ST_CHK_LO: begin t_e_o = '0; t_m_o = '0; t_d_o = DEXP_W'(DEXP_MAX); end
         ST_CHK_HI: begin t_e_o = '1; t_m_o = '1; t_d_o = '0; end
         ST_CHK_BR: begin t_e_o = '0; t_m_o = '0; t_d_o = '0; end
         ST_DIV_UP: begin t_e_o = '0; t_m_o = '0; end
         ST_EXP_DN: begin t_m_o = '0; t_d_o = '0; end
         default: ;
      endcase
   end

   assign t_mode_o    = mode_q;
   assign t_top_o     = top_q;
   assign div_start_o = (state_q == ST_DIV_GO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= ENC_RATE;
         top_q   <= 1'b0;
         req_q   <= '0;
         e_q     <= '0;
         m_q     <= '0;
         d_q     <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         mant_q  <= '0;
         exp_q   <= '0;
         dexp_q  <= '0;
         ach_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (reject) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            mant_q  <= '0;
            exp_q   <= '0;
            dexp_q  <= '0;
            ach_q   <= '0;
            state_q <= ST_IDLE;
         end else begin
            case (state_q)
               ST_IDLE: if (start_i) begin
                  mode_q  <= enc_mode_e'(mode_i);
                  top_q   <= top_i;
                  req_q   <= req_i;
                  state_q <= ST_CHK_LO;
               end
               ST_CHK_LO: state_q <= ST_CHK_HI;
               ST_CHK_HI: begin
                  d_q <= '0;
                  if (mode_q == ENC_BURST) begin
                     e_q     <= '1;
                     state_q <= ST_EXP_DN;
                  end else begin
                     state_q <= ST_CHK_BR;
                  end
               end
               ST_CHK_BR: begin
                  d_q <= '0;
                  if (above) begin
                     e_q     <= '1;
                     state_q <= ST_EXP_DN;
                  end else begin
                     e_q     <= '0;
                     state_q <= ST_DIV_UP;
                  end
               end
               ST_DIV_UP: begin
                  if (below && (d_q != DEXP_W'(DEXP_MAX))) begin
                     d_q <= d_q + DEXP_W'(1);
                  end else begin
                     m_q     <= '1;
                     state_q <= ST_MANT_DN;
                  end
               end
               ST_EXP_DN: begin
                  if (below && (e_q != '0)) begin
                     e_q <= e_q - EXP_W'(1);
                  end else begin
                     m_q     <= '1;
                     state_q <= ST_MANT_DN;
                  end
               end
               ST_MANT_DN: begin
                  if (below && (m_q != '0)) m_q <= m_q - MANT_W'(1);
                  else                      state_q <= ST_DIV_GO;
               end
               ST_DIV_GO: state_q <= ST_DIV_WAIT;
               ST_DIV_WAIT: if (div_done_i) begin
                  done_q  <= 1'b1;
                  err_q   <= 1'b0;
                  mant_q  <= m_q;
                  exp_q   <= e_q;
                  dexp_q  <= d_q;
                  ach_q   <= div_quo_i;
                  state_q <= ST_IDLE;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;
   assign err_o      = err_q;
   assign mant_o     = mant_q;
   assign exp_o      = exp_q;
   assign dexp_o     = dexp_q;
   assign achieved_o = ach_q;

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> state_q == ST_IDLE);
   a_r11_req_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(req_q) && $stable(mode_q) && $stable(top_q));
   a_r2_reject_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && err_q) |-> (ach_q == '0) && (mant_q == '0) && (exp_q == '0) && (dexp_q == '0));
   a_r4_divider_implies_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !err_q && dexp_q != '0) |-> exp_q == '0);
   a_r5_shift_implies_no_divider: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !err_q && exp_q != '0) |-> dexp_q == '0);
   a_r12_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> $stable(ach_q) && $stable(err_q) && $stable(mant_q) && $stable(exp_q));

endmodule

// File: rtl/shaper_param_encoder.sv
module shaper_param_encoder
   import shaper_enc_pkg::*;
#(
   parameter int REQ_W    = 40,
   parameter int CLK_HZ   = 1_000_000_000,
   parameter int TICK_TOP = 240,
   parameter int TICK_LOW = 860,
   parameter int MANT_W   = 8,
   parameter int EXP_W    = 4,
   parameter int DEXP_W   = 4,
   parameter int DEXP_MAX = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               mode_i,
   input  logic               top_lvl_i,
   input  logic [REQ_W-1:0]   req_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               err_o,
   output logic [MANT_W-1:0]  mant_o,
   output logic [EXP_W-1:0]   exp_o,
   output logic [DEXP_W-1:0]  dexp_o,
   output logic [REQ_W-1:0]   achieved_o
);

   localparam int CLK_W  = $clog2(CLK_HZ + 1);
   localparam int TICK_M = (TICK_TOP > TICK_LOW) ? TICK_TOP : TICK_LOW;
   localparam int TICK_W = $clog2(TICK_M + 1);
   localparam int NUM_W  = CLK_W + MANT_W + (1 << EXP_W);
   localparam int DEN_W  = TICK_W + DEXP_MAX + MANT_W;

   if (DEXP_MAX >= (1 << DEXP_W)) begin : g_bad_dexp
      $error("DEXP_MAX does not fit in DEXP_W bits");
   end
   if (REQ_W > NUM_W) begin : g_bad_req_wide
      $error("REQ_W exceeds the quotient width");
   end
   if (REQ_W < MANT_W + (1 << EXP_W) + 2) begin : g_bad_req_narrow
      $error("REQ_W too narrow for the largest burst");
   end

   enc_mode_e         t_mode;
   logic              t_top;
   logic [EXP_W-1:0]  t_e;
   logic [MANT_W-1:0] t_m;
   logic [DEXP_W-1:0] t_d;
   logic [NUM_W-1:0]  num;
   logic [DEN_W-1:0]  den;
   logic              div_start, div_done;
   logic [REQ_W-1:0]  div_quo;

   shaper_enc_ctrl #(
      .REQ_W(REQ_W), .MANT_W(MANT_W), .EXP_W(EXP_W), .DEXP_W(DEXP_W),
      .DEXP_MAX(DEXP_MAX), .NUM_W(NUM_W), .DEN_W(DEN_W)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .top_i(top_lvl_i), .req_i(req_i),
      .t_mode_o(t_mode), .t_top_o(t_top), .t_e_o(t_e), .t_m_o(t_m), .t_d_o(t_d),
      .num_i(num), .den_i(den),
      .div_start_o(div_start), .div_done_i(div_done), .div_quo_i(div_quo),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
      .mant_o(mant_o), .exp_o(exp_o), .dexp_o(dexp_o), .achieved_o(achieved_o)
   );

   shaper_enc_terms #(
      .CLK_HZ(CLK_HZ), .TICK_TOP(TICK_TOP), .TICK_LOW(TICK_LOW),
      .MANT_W(MANT_W), .EXP_W(EXP_W), .DEXP_W(DEXP_W),
      .NUM_W(NUM_W), .DEN_W(DEN_W)
   ) terms_i (
      .mode_i(t_mode), .top_i(t_top), .e_i(t_e), .m_i(t_m), .d_i(t_d),
      .num_o(num), .den_o(den)
   );

   shaper_div_seq #(
      .NUM_W(NUM_W), .DEN_W(DEN_W), .QUO_W(REQ_W)
   ) div_i (
      .clk(clk), .rst_n(rst_n), .start_i(div_start),
      .num_i(num), .den_i(den), .done_o(div_done), .quo_o(div_quo)
   );

endmodule

// File: tb/shaper_param_encoder_tb_top.sv
module shaper_param_encoder_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int REQ_W = 40;
   localparam longint unsigned CK = 64'd1000000000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic mode = 1'b0;
   logic top = 1'b0;
   logic [REQ_W-1:0] req = '0;
   logic busy, done, err;
   logic [7:0] mant;
   logic [3:0] ex, dx;
   logic [REQ_W-1:0] ach;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shaper_param_encoder dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
      .top_lvl_i(top), .req_i(req), .busy_o(busy), .done_o(done),
      .err_o(err), .mant_o(mant), .exp_o(ex), .dexp_o(dx), .achieved_o(ach)
   );

   task automatic check(input bit ok, input string rq, input string what,
                        input longint unsigned act, input longint unsigned exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   function automatic longint unsigned rate_of(longint unsigned t, int e, int m, int d);
      return (CK * ((64'd256 + 64'(m)) << e)) / ((t << d) * 64'd256);
   endfunction

   function automatic longint unsigned burst_of(int e, int m);
      return ((64'd256 + 64'(m)) << (e + 1)) / 64'd256;
   endfunction

   // Reference model: same searches, evaluated with true division
   task automatic ref_enc(input bit md, input bit tp, input longint unsigned v,
                          output bit rj, output int e, output int m, output int d,
                          output longint unsigned a);
      longint unsigned t;
      t = tp ? 64'd240 : 64'd860;
      rj = 1'b0; e = 0; m = 0; d = 0; a = 0;
      if (!md) begin
         if (v < rate_of(t, 0, 0, 12) || v > rate_of(t, 15, 255, 0)) rj = 1'b1;
         else if (v <= rate_of(t, 0, 0, 0)) begin
            m = 255;
            while (v < CK / (t << d)) d++;
            while (v < rate_of(t, 0, m, d)) m--;
            a = rate_of(t, e, m, d);
         end else begin
            e = 15; m = 255;
            while (v < (CK * (64'd1 << e)) / t) e--;
            while (v < rate_of(t, e, m, 0)) m--;
            a = rate_of(t, e, m, d);
         end
      end else begin
         if (v < burst_of(0, 0) || v > burst_of(15, 255)) rj = 1'b1;
         else begin
            e = 15; m = 255;
            while (v < (64'd1 << (e + 1))) e--;
            while (v < burst_of(e, m)) m--;
            a = burst_of(e, m);
         end
      end
   endtask

   // Issues one request; lat counts falling edges from start taken to done
   task automatic run(input bit md, input bit tp, input longint unsigned v, output int lat);
      @(negedge clk);
      mode = md; top = tp; req = REQ_W'(v); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 3000) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic t_encode(input bit md, input bit tp, input longint unsigned v, input string rq);
      bit rj; int e, m, d, lat; longint unsigned a;
      ref_enc(md, tp, v, rj, e, m, d, a);
      run(md, tp, v, lat);
      check(done == 1'b1, rq, "done seen", 64'(done), 1);
      check(err == rj, rq, "error flag", 64'(err), 64'(rj));
      check(ach == REQ_W'(a), rq, "achieved (R9)", 64'(ach), a);
      check(mant == 8'(m), rq, "mantissa", 64'(mant), 64'(m));
      check(ex == 4'(e), rq, "exponent", 64'(ex), 64'(e));
      check(dx == 4'(d), rq, "divider exponent", 64'(dx), 64'(d));
   endtask

   task automatic t_reject(input bit md, input bit tp, input longint unsigned v,
                           input int exp_lat, input string rq);
      int lat;
      run(md, tp, v, lat);
      check(lat == exp_lat, rq, "refusal latency", 64'(lat), 64'(exp_lat));
      check(err == 1'b1, rq, "refusal error flag", 64'(err), 1);
      check(ach == '0 && mant == '0 && ex == '0 && dx == '0, rq, "refusal zero outputs", 64'(ach), 0);
   endtask

   task automatic t_handshake();
      int lat;
      @(negedge clk);
      mode = 1'b0; top = 1'b0; req = REQ_W'(64'd5000); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1 && done == 1'b0, "R10", "busy after start", 64'(busy), 1);
      lat = 1;
      while (!done && lat < 3000) begin @(negedge clk); lat++; end
      check(busy == 1'b0, "R10", "busy low with done", 64'(busy), 0);
      @(negedge clk);
      check(done == 1'b0, "R10", "done single cycle", 64'(done), 0);
   endtask

   task automatic t_ignore_busy();
      bit rj; int e, m, d, lat; longint unsigned a;
      ref_enc(1'b0, 1'b0, 64'd5000, rj, e, m, d, a);
      @(negedge clk);
      mode = 1'b0; top = 1'b0; req = REQ_W'(64'd5000); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      mode = 1'b1; top = 1'b1; req = REQ_W'(64'd1000); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 3000) begin @(negedge clk); lat++; end
      check(ach == REQ_W'(a), "R11", "result of first request", 64'(ach), a);
      check(mant == 8'(m) && dx == 4'(d), "R11", "fields of first request", 64'(mant), 64'(m));
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R11", "second strobe not queued", 64'(busy), 0);
   endtask

   task automatic t_hold();
      logic [REQ_W-1:0] a0; logic [7:0] m0; logic e0;
      int lat;
      run(1'b1, 1'b0, 64'd77777, lat);
      a0 = ach; m0 = mant; e0 = err;
      @(negedge clk);
      req = REQ_W'(64'd3); mode = 1'b0;
      repeat (20) @(negedge clk);
      check(ach == a0 && mant == m0 && err == e0, "R12", "outputs held", 64'(ach), 64'(a0));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy == 0 && done == 0 && err == 0 && ach == '0 && mant == '0 && ex == '0 && dx == '0,
            "R1", "reset state", 64'(ach), 0);
      rst_n = 1'b1;
      // R2 / R3 / R8 refusals and their timing
      t_reject(1'b0, 1'b0, 64'd282, 2, "R2");
      t_reject(1'b0, 1'b1, 64'd1016, 2, "R2");
      t_reject(1'b0, 1'b0, 64'd76055813954, 3, "R3");
      t_reject(1'b0, 1'b1, 64'd272533333334, 3, "R3");
      t_reject(1'b1, 1'b0, 64'd1, 2, "R8");
      t_reject(1'b1, 1'b0, 64'd130817, 3, "R8");
      // R4 low branch, including range floor and branch boundary
      t_encode(1'b0, 1'b0, 64'd283, "R4");
      t_encode(1'b0, 1'b0, 64'd5000, "R4");
      t_encode(1'b0, 1'b0, 64'd1162790, "R4");
      t_encode(1'b0, 1'b1, 64'd1000000, "R4");
      // R5 high branch, including range ceiling
      t_encode(1'b0, 1'b0, 64'd1162791, "R5");
      t_encode(1'b0, 1'b0, 64'd10000000000, "R5");
      t_encode(1'b0, 1'b0, 64'd76055813953, "R5");
      t_encode(1'b0, 1'b1, 64'd272533333333, "R5");
      // R6 tick period: 1000 is legal at 860 ticks, refused at 240
      t_encode(1'b0, 1'b0, 64'd1000, "R6");
      t_reject(1'b0, 1'b1, 64'd1000, 2, "R6");
      t_encode(1'b0, 1'b1, 64'd1017, "R6");
      // R7 bursts
      t_encode(1'b1, 1'b0, 64'd2, "R7");
      t_encode(1'b1, 1'b0, 64'd1000, "R7");
      t_encode(1'b1, 1'b1, 64'd77777, "R7");
      t_encode(1'b1, 1'b0, 64'd130816, "R7");
      t_handshake();
      t_ignore_busy();
      t_hold();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R10 watchdog: actual no completion expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule